// File: doc/BRIEF.md
# Pixel Data Mode and Bus Width Formatter

This block sits between a host write port and a display bitmap memory, and between that memory and the panel drive logic. On the write side it takes a column address, host data and the current access width. It produces the memory write word and per-nibble write enables. In narrow (8-bit) access only the low byte is written. In wide (16-bit) access the full word is written, except at a few edge columns where the memory word is only partly populated. At those columns the unused low data bits are zeroed and their nibble enables are dropped, so a truncated write can never alter a stored bit it does not own.

On the read side it turns a memory word into pixel drive values. In grayscale mode every two bits form a code that picks one of four programmable 4-bit levels. In mono mode every bit is one pixel, shown on or off, with an optional inverted polarity. All outputs are registered, one clock after their inputs. The four levels live in small registers, loaded one at a time by a strobe.

Top module: `pixel_bus_fmt`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `ram_we`, `ram_wdata`, `ram_col`, `gray_lvl` and `mono_on` are zero. The four gray levels reset to 0, 5, 10 and 15 for codes 00, 01, 10 and 11.
- R2: A write in narrow mode (`bus16`=0) outputs `ram_we`=4'b0011 and `ram_wdata`={8'h00, wr_data[7:0]} at any column. The upper data byte has no effect.
- R3: A write in wide mode (`bus16`=1) at a non-edge column outputs `ram_we`=4'b1111 and `ram_wdata`=wr_data.
- R4: A wide grayscale write at column 16 outputs `ram_we`=4'b1100 with `ram_wdata`[7:0] zero. Data bits 7..0 are ignored.
- R5: A wide mono write at column 8 with `layer_sel`=0, or at column 40 with `layer_sel`=1, outputs `ram_we`=4'b1000 with `ram_wdata`[11:0] zero. Those columns with the other layer are written in full.
- R6: When `wr_valid` is low, `ram_we` is 4'b0000, `ram_wdata` is zero and `ram_col` is zero.
- R7: In grayscale mode, pixel k takes code rd_data[2k+1:2k] and outputs the level for that code on gray_lvl[4k+3:4k]. `mono_on` is zero.
- R8: A cycle with `lvl_we` high loads `lvl_val` into the level for code `lvl_sel`. The other three levels are unchanged. The new level is used by decode results registered from the next cycle on.
- R9: In mono mode, `mono_on` equals `rd_data` when `neg_pol`=0 and ~`rd_data` when `neg_pol`=1. Bit k is pixel k, and 1 means on. `gray_lvl` is zero.
- R10: Every output changes only at a clock edge, one cycle after the inputs it depends on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gray_mode | input | 1 | 1 = 2-bit grayscale pixels, 0 = 1-bit mono pixels |
| neg_pol | input | 1 | Mono polarity, 1 = inverted |
| bus16 | input | 1 | 1 = 16-bit host access, 0 = 8-bit |
| layer_sel | input | 1 | Mono memory layer, picks which edge column truncates |
| wr_valid | input | 1 | Host write strobe |
| wr_col | input | 6 | Write column address |
| wr_data | input | 16 | Host write data |
| lvl_we | input | 1 | Level register load strobe |
| lvl_sel | input | 2 | Gray code whose level is loaded |
| lvl_val | input | 4 | Level value to load |
| rd_data | input | 16 | Memory word to decode |
| ram_col | output | 6 | Registered write column |
| ram_wdata | output | 16 | Masked write data |
| ram_we | output | 4 | Per-nibble write enables |
| gray_lvl | output | 32 | Eight 4-bit gray drive levels |
| mono_on | output | 16 | Sixteen mono pixel on flags |

## Verification
The write path is walked through every pairing of mode, width, layer and column that matters. These cover narrow writes at an edge column, wide writes at each truncating column, and those same columns under the mode or layer that must not truncate. This separates a column match that ignores the mode from one that ignores the layer. The decoder is given the word 0xE4E4, which holds every code in order, before and after a level reload. This shows a code-to-level swap or a level written to the wrong slot. Mono decode uses a word whose complement differs in every bit, so that a missing or misapplied polarity inversion is visible.

// File: rtl/pxf_pkg.sv
`timescale 1ns/1ps
package pxf_pkg;
    typedef enum logic {BUS_NARROW = 1'b0, BUS_WIDE = 1'b1} bus_w_e;
    typedef enum logic {PIX_MONO = 1'b0, PIX_GRAY = 1'b1} pix_mode_e;

    localparam int unsigned GRAY_LEVELS = 4;

    // Evenly spaced reset level for gray code idx.
    function automatic int unsigned default_level(int unsigned idx, int unsigned w);
        return (((1 << w) - 1) * idx) / (GRAY_LEVELS - 1);
    endfunction
endpackage

// File: rtl/pxf_wr_fmt.sv
`timescale 1ns/1ps
module pxf_wr_fmt
    import pxf_pkg::*;
#(
    parameter int unsigned COL_W      = 6,
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned GRAY_EDGE  = 16,
    parameter int unsigned MONO_EDGE0 = 8,
    parameter int unsigned MONO_EDGE1 = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  bus_w_e            bus_w,
    input  pix_mode_e         mode,
    input  logic              layer,
    input  logic [COL_W-1:0]  col,
    input  logic [DATA_W-1:0] data,
    output logic [COL_W-1:0]  ram_col,
    output logic [DATA_W-1:0] ram_wdata,
    output logic [DATA_W/4-1:0] ram_we
);
    localparam int unsigned NIB      = DATA_W / 4;
    localparam int unsigned HALF_NIB = NIB / 2;

    typedef struct packed {
        logic [COL_W-1:0]  col;
        logic [DATA_W-1:0] wdata;
        logic [NIB-1:0]    we;
    } wr_state_t;

    wr_state_t st_d, st_q;
    logic [NIB-1:0] keep;
    logic           gray_cut, mono_cut;

    always_comb begin
        gray_cut = (mode == PIX_GRAY) && (col == COL_W'(GRAY_EDGE));
        mono_cut = (mode == PIX_MONO) &&
                   (col == (layer ? COL_W'(MONO_EDGE1) : COL_W'(MONO_EDGE0)));
        keep = '0;
        if (wr_valid) begin
            if (bus_w == BUS_NARROW) begin
                for (int i = 0; i < 2; i++) keep[i] = 1'b1;
            end else if (gray_cut) begin
                for (int i = 0; i < NIB; i++) keep[i] = (i >= HALF_NIB);
            end else if (mono_cut) begin
                keep[NIB-1] = 1'b1;
            end else begin
                keep = '1;
            end
        end
        st_d.we  = keep;
        st_d.col = wr_valid ? col : '0;
        for (int i = 0; i < NIB; i++)
            st_d.wdata[4*i +: 4] = keep[i] ? data[4*i +: 4] : 4'h0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ram_col   = st_q.col;
    assign ram_wdata = st_q.wdata;
    assign ram_we    = st_q.we;

    assert_idle_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> (ram_we == '0 && ram_wdata == '0));
    assert_narrow_low_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && bus_w == BUS_NARROW) |=> (ram_we[NIB-1:2] == '0 && ram_we[1:0] == 2'b11));
    assert_gray_edge_cut_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && bus_w == BUS_WIDE && gray_cut) |=> (ram_wdata[4*HALF_NIB-1:0] == '0));
    assert_mono_edge_cut_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && bus_w == BUS_WIDE && mono_cut) |=> (ram_we[NIB-2:0] == '0 && ram_wdata[DATA_W-5:0] == '0));
endmodule

// File: rtl/pxf_lvl_bank.sv
`timescale 1ns/1ps
module pxf_lvl_bank
    import pxf_pkg::*;
#(
    parameter int unsigned LVL_W = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  lvl_we,
    input  logic [$clog2(GRAY_LEVELS)-1:0]        lvl_sel,
    input  logic [LVL_W-1:0]                      lvl_val,
    output logic [GRAY_LEVELS-1:0][LVL_W-1:0]     lvl
);
    typedef struct packed {
        logic [GRAY_LEVELS-1:0][LVL_W-1:0] lvl;
    } lvl_state_t;

    lvl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (lvl_we) st_d.lvl[lvl_sel] = lvl_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < GRAY_LEVELS; i++)
                st_q.lvl[i] <= LVL_W'(default_level(i, LVL_W));
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl = st_q.lvl;

    assert_lvl_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !lvl_we |=> $stable(lvl));
    assert_lvl_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_we |=> (lvl[$past(lvl_sel)] == $past(lvl_val)));
endmodule

// File: rtl/pxf_decode.sv
`timescale 1ns/1ps
module pxf_decode
    import pxf_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned LVL_W  = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  pix_mode_e                         mode,
    input  logic                              neg,
    input  logic [DATA_W-1:0]                 rd_data,
    input  logic [GRAY_LEVELS-1:0][LVL_W-1:0] lvl,
    output logic [(DATA_W/2)*LVL_W-1:0]       gray_lvl,
    output logic [DATA_W-1:0]                 mono_on
);
    localparam int unsigned GRAY_PIX = DATA_W / 2;

    typedef struct packed {
        logic [GRAY_PIX*LVL_W-1:0] gray;
        logic [DATA_W-1:0]         mono;
    } dec_state_t;

    dec_state_t st_d, st_q;

    always_comb begin
        st_d = '0;
        if (mode == PIX_GRAY) begin
            for (int k = 0; k < GRAY_PIX; k++)
                st_d.gray[k*LVL_W +: LVL_W] = lvl[rd_data[2*k +: 2]];
        end else begin
            st_d.mono = neg ? ~rd_data : rd_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gray_lvl = st_q.gray;
    assign mono_on  = st_q.mono;

    assert_mono_no_gray_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PIX_MONO) |=> (gray_lvl == '0));
    assert_gray_no_mono_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PIX_GRAY) |=> (mono_on == '0));
    assert_mono_polarity_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PIX_MONO && !neg) |=> (mono_on == $past(rd_data)));
endmodule

// File: rtl/pixel_bus_fmt.sv
`timescale 1ns/1ps
module pixel_bus_fmt
    import pxf_pkg::*;
#(
    parameter int unsigned COL_W      = 6,
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned LVL_W      = 4,
    parameter int unsigned GRAY_EDGE  = 16,
    parameter int unsigned MONO_EDGE0 = 8,
    parameter int unsigned MONO_EDGE1 = 40
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          gray_mode,
    input  logic                          neg_pol,
    input  logic                          bus16,
    input  logic                          layer_sel,
    input  logic                          wr_valid,
    input  logic [COL_W-1:0]              wr_col,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic                          lvl_we,
    input  logic [1:0]                    lvl_sel,
    input  logic [LVL_W-1:0]              lvl_val,
    input  logic [DATA_W-1:0]             rd_data,
    output logic [COL_W-1:0]              ram_col,
    output logic [DATA_W-1:0]             ram_wdata,
    output logic [DATA_W/4-1:0]           ram_we,
    output logic [(DATA_W/2)*LVL_W-1:0]   gray_lvl,
    output logic [DATA_W-1:0]             mono_on
);
    pix_mode_e mode;
    bus_w_e    bus_w;
    logic [GRAY_LEVELS-1:0][LVL_W-1:0] lvl;

    assign mode  = gray_mode ? PIX_GRAY : PIX_MONO;
    assign bus_w = bus16 ? BUS_WIDE : BUS_NARROW;

    pxf_wr_fmt #(
        .COL_W(COL_W), .DATA_W(DATA_W), .GRAY_EDGE(GRAY_EDGE),
        .MONO_EDGE0(MONO_EDGE0), .MONO_EDGE1(MONO_EDGE1)
    ) u_wr (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .bus_w(bus_w),
        .mode(mode), .layer(layer_sel), .col(wr_col), .data(wr_data),
        .ram_col(ram_col), .ram_wdata(ram_wdata), .ram_we(ram_we)
    );

    pxf_lvl_bank #(.LVL_W(LVL_W)) u_lvl (
        .clk(clk), .rst_n(rst_n), .lvl_we(lvl_we), .lvl_sel(lvl_sel),
        .lvl_val(lvl_val), .lvl(lvl)
    );

    pxf_decode #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .mode(mode), .neg(neg_pol),
        .rd_data(rd_data), .lvl(lvl), .gray_lvl(gray_lvl), .mono_on(mono_on)
    );
endmodule

// File: tb/pixel_bus_fmt_test.sv
`timescale 1ns/1ps
module pixel_bus_fmt_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        gray_mode, neg_pol, bus16, layer_sel, wr_valid, lvl_we;
    logic [5:0]  wr_col;
    logic [15:0] wr_data, rd_data;
    logic [1:0]  lvl_sel;
    logic [3:0]  lvl_val;
    logic [5:0]  ram_col;
    logic [15:0] ram_wdata, mono_on;
    logic [3:0]  ram_we;
    logic [31:0] gray_lvl;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;
    logic [3:0] lvl_model [4];

    always #4 clk = ~clk;

    pixel_bus_fmt uut (
        .clk(clk), .rst_n(rst_n), .gray_mode(gray_mode), .neg_pol(neg_pol),
        .bus16(bus16), .layer_sel(layer_sel), .wr_valid(wr_valid),
        .wr_col(wr_col), .wr_data(wr_data), .lvl_we(lvl_we), .lvl_sel(lvl_sel),
        .lvl_val(lvl_val), .rd_data(rd_data), .ram_col(ram_col),
        .ram_wdata(ram_wdata), .ram_we(ram_we), .gray_lvl(gray_lvl), .mono_on(mono_on)
    );

    typedef struct packed {
        logic        gray;
        logic        wide;
        logic        layer;
        logic [5:0]  col;
        logic [15:0] data;
        logic [3:0]  we;
        logic [15:0] wd;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b0, 6'd5,  16'hA5C3, 4'b0011, 16'h00C3}, // R2
        '{1'b1, 1'b0, 1'b0, 6'd16, 16'h1234, 4'b0011, 16'h0034}, // R2 edge col in narrow
        '{1'b1, 1'b1, 1'b0, 6'd3,  16'hBEEF, 4'b1111, 16'hBEEF}, // R3
        '{1'b1, 1'b1, 1'b0, 6'd16, 16'hABCD, 4'b1100, 16'hAB00}, // R4
        '{1'b0, 1'b1, 1'b0, 6'd16, 16'hABCD, 4'b1111, 16'hABCD}, // R3 mono at gray edge
        '{1'b0, 1'b1, 1'b0, 6'd8,  16'hF00D, 4'b1000, 16'hF000}, // R5 layer 0
        '{1'b0, 1'b1, 1'b1, 6'd40, 16'h7654, 4'b1000, 16'h7000}, // R5 layer 1
        '{1'b0, 1'b1, 1'b0, 6'd40, 16'h7654, 4'b1111, 16'h7654}, // R5 wrong layer
        '{1'b0, 1'b1, 1'b1, 6'd8,  16'h1357, 4'b1111, 16'h1357}, // R5 wrong layer
        '{1'b1, 1'b1, 1'b0, 6'd8,  16'h2468, 4'b1111, 16'h2468}  // R3 gray at mono edge
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] gray_expect(input logic [15:0] w);
        logic [31:0] r;
        for (int k = 0; k < 8; k++) r[4*k +: 4] = lvl_model[w[2*k +: 2]];
        return r;
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #800000;
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        lvl_model[0] = 4'd0; lvl_model[1] = 4'd5;
        lvl_model[2] = 4'd10; lvl_model[3] = 4'd15;
        rst_n = 0; gray_mode = 1; neg_pol = 0; bus16 = 0; layer_sel = 0;
        wr_valid = 1; wr_col = 6'd3; wr_data = 16'hFFFF; lvl_we = 0;
        lvl_sel = 0; lvl_val = 0; rd_data = 16'hE4E4;
        repeat (3) step();
        // R1: outputs held at zero during reset
        check("R1 we in reset", {28'd0, ram_we}, 32'd0);
        check("R1 wdata in reset", {16'd0, ram_wdata}, 32'd0);
        check("R1 gray in reset", gray_lvl, 32'd0);
        wr_valid = 0;
        rst_n = 1;
        step();
        // R1: default levels 0,5,10,15 seen via decode of 0xE4E4
        check("R1 default levels", gray_lvl, gray_expect(16'hE4E4));
        check("R1 col after reset", {26'd0, ram_col}, 32'd0);
        check("R7 mono zero in gray", {16'd0, mono_on}, 32'd0);

        // Table walk of the write path (R2..R5)
        for (int i = 0; i < NV; i++) begin
            gray_mode = VECS[i].gray; bus16 = VECS[i].wide;
            layer_sel = VECS[i].layer; wr_col = VECS[i].col;
            wr_data = VECS[i].data; wr_valid = 1;
            step();
            check($sformatf("R2-5 vec %0d we", i), {28'd0, ram_we}, {28'd0, VECS[i].we});
            check($sformatf("R2-5 vec %0d wdata", i), {16'd0, ram_wdata}, {16'd0, VECS[i].wd});
            check($sformatf("R2-5 vec %0d col", i), {26'd0, ram_col}, {26'd0, VECS[i].col});
        end

        // R6: idle cycle writes nothing
        wr_valid = 0; wr_data = 16'hDEAD; bus16 = 1; wr_col = 6'd9;
        step();
        check("R6 idle we", {28'd0, ram_we}, 32'd0);
        check("R6 idle wdata", {16'd0, ram_wdata}, 32'd0);

        // R10: output holds until the next edge
        wr_valid = 1; wr_data = 16'h4321; wr_col = 6'd2; gray_mode = 1;
        #1;
        check("R10 no change before edge", {28'd0, ram_we}, 32'd0);
        step();
        check("R10 change after edge", {16'd0, ram_wdata}, 32'h4321);
        wr_valid = 0;

        // R8: reload level for code 10 to 3
        gray_mode = 1; rd_data = 16'hE4E4;
        lvl_we = 1; lvl_sel = 2'd2; lvl_val = 4'd3;
        step();
        lvl_we = 0; lvl_model[2] = 4'd3;
        step();
        check("R8 reloaded level", gray_lvl, gray_expect(16'hE4E4));
        check("R8 exact word", gray_lvl, 32'hF350F350);

        // R7: different pattern, all code 11 and 00 mixed
        rd_data = 16'h0FF0;
        step();
        check("R7 gray pattern", gray_lvl, gray_expect(16'h0FF0));

        // R9: mono positive and negative
        gray_mode = 0; neg_pol = 0; rd_data = 16'h5A3C;
        step();
        check("R9 mono positive", {16'd0, mono_on}, 32'h5A3C);
        check("R9 gray zero in mono", gray_lvl, 32'd0);
        neg_pol = 1;
        step();
        check("R9 mono negative", {16'd0, mono_on}, 32'hA5C3);

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule